// File: doc/BRIEF.md
# Seconds Counter Real-Time Clock

This peripheral keeps time as a single unsigned 32-bit count of whole seconds. A prescaler divides the reference clock by a parameter, `CLK_HZ`. Each time it completes a full second it produces a one-cycle tick, and that tick advances the count. Software can preload the count at any moment, which also restarts the second currently in progress. Software can also program an alarm value. When a tick brings the count equal to that value, a sticky status bit is raised. The status bit is gated by a one-bit mask to form a registered interrupt line.

Access is through a simple single-cycle 32-bit register port. The port carries a word index covering a 4 KB window. Writes take effect on the clock edge on which `bus_wr` is high. Reads are combinational from the registered state. The eight registers sit at the bottom of the window. A fixed block of identification bytes sits at its top, one byte per word. Everything else in the window reads as zero and ignores writes.

Top module: `rtcs_top`

## Requirements
- R1: After a synchronous active-low reset, the following all read 0: count, alarm, load, mask, raw status and masked status. The interrupt output is 0.
- R2: The registers are found at these word indices (byte offset divided by 4): 0 count, 1 alarm, 2 load, 3 control, 4 mask, 5 raw status, 6 masked status, 7 clear. Reading index 0 returns the count. The count increases by one on every CLK_HZ-th clock edge, measured from the last reset or load.
- R3: A write to index 2 stores the data, which then reads back from index 2. The same edge sets the count to that data and restarts the sub-second phase. The next increment therefore comes exactly CLK_HZ edges after the write.
- R4: The alarm register at index 1 is read/write and returns the last value written.
- R5: Raw status (bit 0 at index 5) is set only by a tick that makes the count equal to the alarm value. A load of a value equal to the alarm does not set it.
- R6: The mask register (index 4) keeps only write-data bit 0. Its bits 31:1 always read 0.
- R7: A write of any data to index 7 clears raw status. If a setting tick falls on the same edge, raw status stays set.
- R8: Masked status (index 6) reads as raw status AND mask. The `irq` output is a register that always equals masked status.
- R9: The control register (index 3) always reads 1, and writes to it change nothing.
- R10: Word indices 0x3F8 to 0x3FF return, in bits 7:0 with the upper bits zero, the bytes 0x31, 0x10, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1 in index order. Writes to them are ignored.
- R11: Reads from the clear register and from reserved indices 8 to 0x3F7 return 0. Writes to reserved indices change no readable state.
- R12: The count wraps from 0xFFFFFFFF to 0 on a tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Access strobe for the current cycle |
| bus_wr | input | 1 | 1 = write, 0 = read, qualified by bus_sel |
| bus_word | input | 10 | Word index in the 4 KB window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of a read |
| irq | output | 1 | Registered alarm interrupt, masked |

## Verification
The bench aims at the edge where a load lands: if the prescaler phase were not cleared, the first increment after a load would arrive early, before the CLK_HZ-th edge. It places a clear write on exactly the edge of an alarm tick. A design that lets the clear win would lose the alarm, with raw status reading 0. A load straight onto the alarm value is also tried; a comparator that watches the count instead of the tick would raise a false alarm. A count sitting at all ones must roll to 0. Stores of all-ones to the mask, writes to the control register and writes to the identification words must leave every readback unchanged, and a design that latched them would return stale or extra bits.

// File: rtl/rtcs_pkg.sv
// Package: shared constants for the seconds-counter RTC.
// Assumes word-indexed access into a 4 KB window (1024 words).
package rtcs_pkg;

    localparam int WORD_W  = 10;
    localparam int DATA_W  = 32;

    localparam logic [WORD_W-1:0] IDX_COUNT  = 10'd0;
    localparam logic [WORD_W-1:0] IDX_ALARM  = 10'd1;
    localparam logic [WORD_W-1:0] IDX_LOAD   = 10'd2;
    localparam logic [WORD_W-1:0] IDX_CTRL   = 10'd3;
    localparam logic [WORD_W-1:0] IDX_MASK   = 10'd4;
    localparam logic [WORD_W-1:0] IDX_RAW    = 10'd5;
    localparam logic [WORD_W-1:0] IDX_MASKED = 10'd6;
    localparam logic [WORD_W-1:0] IDX_CLEAR  = 10'd7;

    // Upper seven index bits that select the identification block.
    localparam logic [6:0] ID_REGION = 7'h7F;

    // Identification byte for position 0..7 inside the ID block.
    function automatic logic [7:0] id_byte(input logic [2:0] pos);
        case (pos)
            3'd0:    id_byte = 8'h31;
            3'd1:    id_byte = 8'h10;
            3'd2:    id_byte = 8'h14;
            3'd3:    id_byte = 8'h00;
            3'd4:    id_byte = 8'h0D;
            3'd5:    id_byte = 8'hF0;
            3'd6:    id_byte = 8'h05;
            default: id_byte = 8'hB1;
        endcase
    endfunction

endpackage

// File: rtl/rtcs_prescaler.sv
// Module: divides the reference clock into a one-cycle tick every CLK_HZ cycles.
// Assumes CLK_HZ >= 1; a restart request zeroes the phase and suppresses
// the tick in that cycle.
module rtcs_prescaler #(
    parameter int CLK_HZ = 32768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);

    localparam int CNT_W = (CLK_HZ > 1) ? $clog2(CLK_HZ) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CLK_HZ - 1);

    logic [CNT_W-1:0] phase_q;
    logic             at_last;

    // Decode the final cycle of each second.
    always_comb begin
        at_last = (phase_q == LAST);
        tick    = at_last && !restart;
    end

    // Advance the sub-second phase, wrapping or restarting to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (restart || at_last) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + CNT_W'(1);
        end
    end

    generate
        if (CLK_HZ > 1) begin : g_spacing_checks
            AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick); // R2
            AST_RESTART_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
                restart |=> !tick); // R3
        end
    endgenerate

endmodule

// File: rtl/rtcs_counter.sv
// Module: the seconds count with preload and alarm equality detection.
// Assumes tick and load_en come from the same clock; load wins over tick.
module rtcs_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_en,
    input  logic [W-1:0] load_val,
    input  logic         tick,
    input  logic [W-1:0] alarm_val,
    output logic [W-1:0] count,
    output logic         hit
);

    logic [W-1:0] count_q;
    logic [W-1:0] count_inc;

    // Next count and the alarm hit for a tick that is about to land.
    always_comb begin
        count_inc = count_q + W'(1);
        hit       = tick && !load_en && (count_inc == alarm_val);
        count     = count_q;
    end

    // Hold, preload or advance the seconds count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (load_en) begin
            count_q <= load_val;
        end else if (tick) begin
            count_q <= count_inc;
        end
    end

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load_en) |=> (count == $past(count) + W'(1))); // R12
    AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !load_en) |=> $stable(count)); // R2
    AST_LOAD_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> (count == $past(load_val))); // R3

endmodule

// File: rtl/rtcs_irq_status.sv
// Module: sticky alarm status, one-bit mask and registered interrupt line.
// Assumes hit is a single-cycle pulse; a set and a clear on one edge keep
// the status set.
module rtcs_irq_status (
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic clr,
    input  logic mask_we,
    input  logic mask_d,
    output logic raw,
    output logic mask,
    output logic irq
);

    logic raw_q, mask_q, irq_q;
    logic raw_nxt, mask_nxt;

    // Next-state of status and mask, set taking priority over clear.
    always_comb begin
        raw_nxt  = hit || (raw_q && !clr);
        mask_nxt = mask_we ? mask_d : mask_q;
    end

    // Register status, mask and the interrupt derived from their next values.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raw_q  <= 1'b0;
            mask_q <= 1'b0;
            irq_q  <= 1'b0;
        end else begin
            raw_q  <= raw_nxt;
            mask_q <= mask_nxt;
            irq_q  <= raw_nxt && mask_nxt;
        end
    end

    assign raw  = raw_q;
    assign mask = mask_q;
    assign irq  = irq_q;

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> raw); // R7
    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !hit) |=> !raw); // R7
    AST_RAW_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(raw) |-> $past(hit)); // R5
    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (raw && mask)); // R8

endmodule

// File: rtl/rtcs_top.sv
// Module: seconds-counter RTC with a word-indexed register port.
// Assumes single-cycle accesses: writes commit on the edge where
// bus_sel && bus_wr, reads are combinational in the same cycle.
module rtcs_top #(
    parameter int CLK_HZ = 32768
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic [9:0]  bus_word,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        irq
);

    import rtcs_pkg::*;

    logic              wr_en, rd_en;
    logic              we_alarm, we_load, we_mask, we_clear;
    logic [DATA_W-1:0] alarm_q, load_q, count;
    logic              tick, hit, raw, mask;
    logic              in_id;

    // Decode the write strobes for each writable register.
    always_comb begin
        wr_en    = bus_sel && bus_wr;
        rd_en    = bus_sel && !bus_wr;
        we_alarm = wr_en && (bus_word == IDX_ALARM);
        we_load  = wr_en && (bus_word == IDX_LOAD);
        we_mask  = wr_en && (bus_word == IDX_MASK);
        we_clear = wr_en && (bus_word == IDX_CLEAR);
        in_id    = (bus_word[9:3] == ID_REGION);
    end

    // Hold the alarm value and the last loaded value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alarm_q <= '0;
            load_q  <= '0;
        end else begin
            if (we_alarm) alarm_q <= bus_wdata;
            if (we_load)  load_q  <= bus_wdata;
        end
    end

    rtcs_prescaler #(.CLK_HZ(CLK_HZ)) i_prescaler (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (we_load),
        .tick    (tick)
    );

    rtcs_counter #(.W(DATA_W)) i_counter (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_en   (we_load),
        .load_val  (bus_wdata),
        .tick      (tick),
        .alarm_val (alarm_q),
        .count     (count),
        .hit       (hit)
    );

    rtcs_irq_status i_irq_status (
        .clk     (clk),
        .rst_n   (rst_n),
        .hit     (hit),
        .clr     (we_clear),
        .mask_we (we_mask),
        .mask_d  (bus_wdata[0]),
        .raw     (raw),
        .mask    (mask),
        .irq     (irq)
    );

    // Select read data from the register file, ID block or zero.
    always_comb begin
        bus_rdata = '0;
        if (rd_en) begin
            if (in_id) begin
                bus_rdata = {24'd0, id_byte(bus_word[2:0])};
            end else begin
                case (bus_word)
                    IDX_COUNT:  bus_rdata = count;
                    IDX_ALARM:  bus_rdata = alarm_q;
                    IDX_LOAD:   bus_rdata = load_q;
                    IDX_CTRL:   bus_rdata = 32'd1;
                    IDX_MASK:   bus_rdata = {31'd0, mask};
                    IDX_RAW:    bus_rdata = {31'd0, raw};
                    IDX_MASKED: bus_rdata = {31'd0, raw && mask};
                    default:    bus_rdata = '0;
                endcase
            end
        end
    end

    AST_LOAD_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
        we_load |=> (load_q == count)); // R3
    AST_ALARM_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        !we_alarm |=> $stable(alarm_q)); // R4
    AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && bus_word == IDX_MASKED) |-> (bus_rdata[0] == irq)); // R8

endmodule

// File: tb/test_rtcs_top.sv
// Bench: behavioural reference model updated every clock and compared on
// every cycle, plus directed checks on the boundary cases.
module test_rtcs_top;

    localparam int HZ = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [9:0]  bus_word = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk; // 125 MHz

    rtcs_top #(.CLK_HZ(HZ)) i_rtcs_top (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_word(bus_word), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    // Reference model state.
    logic [31:0] m_sec, m_alarm, m_load;
    int          m_phase;
    bit          m_mask, m_raw, m_irq;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_sec = 0; m_alarm = 0; m_load = 0; m_phase = 0;
            m_mask = 0; m_raw = 0; m_irq = 0;
        end else begin
            bit wr, set;
            wr = bus_sel && bus_wr;
            set = 0;
            if (wr && bus_word == 10'd2) begin
                m_sec = bus_wdata; m_load = bus_wdata; m_phase = 0;
            end else if (m_phase == HZ - 1) begin
                m_phase = 0;
                m_sec = m_sec + 1;
                if (m_sec == m_alarm) set = 1;
            end else begin
                m_phase++;
            end
            if (set) m_raw = 1;
            else if (wr && bus_word == 10'd7) m_raw = 0;
            if (wr && bus_word == 10'd1) m_alarm = bus_wdata;
            if (wr && bus_word == 10'd4) m_mask = bus_wdata[0];
            m_irq = m_raw && m_mask;
        end
    end

    function automatic logic [31:0] model_read(input logic [9:0] w);
        logic [7:0] ids [8] = '{8'h31, 8'h10, 8'h14, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
        if (w >= 10'h3F8) return {24'd0, ids[w - 10'h3F8]};
        case (w)
            10'd0: return m_sec;
            10'd1: return m_alarm;
            10'd2: return m_load;
            10'd3: return 32'd1;
            10'd4: return {31'd0, m_mask};
            10'd5: return {31'd0, m_raw};
            10'd6: return {31'd0, m_raw && m_mask};
            default: return 32'd0;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Every-cycle comparison against the model (R8 for irq, R2/R10/R11 for reads).
    always @(negedge clk) begin
        #1;
        if (rst_n && !done) begin
            check("R8 irq line", {31'd0, irq}, {31'd0, m_irq});
            if (bus_sel && !bus_wr)
                check("R2 R10 R11 model read", bus_rdata, model_read(bus_word));
        end
    end

    task automatic wr(input logic [9:0] w, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_word = w; bus_wdata = d;
    endtask

    task automatic rd(input logic [9:0] w, input logic [31:0] exp, input string req);
        @(negedge clk);
        bus_sel = 1; bus_wr = 0; bus_word = w; bus_wdata = '0;
        #1;
        check(req, bus_rdata, exp);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            bus_sel = 0; bus_wr = 0;
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;

        // R1: reset values
        rd(10'd1, 0, "R1 alarm");
        rd(10'd2, 0, "R1 load");
        rd(10'd4, 0, "R1 mask");
        rd(10'd5, 0, "R1 raw");
        rd(10'd6, 0, "R1 masked");
        check("R1 irq", {31'd0, irq}, 32'd0);
        idle(2 * HZ + 3);

        // R4: alarm readback
        wr(10'd1, 32'hDEAD_BEEF);
        rd(10'd1, 32'hDEAD_BEEF, "R4 alarm readback");

        // R3: load and phase restart
        wr(10'd2, 32'd1000);
        rd(10'd0, 32'd1000, "R3 count after load");
        rd(10'd2, 32'd1000, "R3 load readback");
        idle(HZ - 3);
        rd(10'd0, 32'd1000, "R3 no early step");
        rd(10'd0, 32'd1001, "R3 step at period");

        // R6: mask keeps bit 0 only
        wr(10'd4, 32'hFFFF_FFFE);
        rd(10'd4, 0, "R6 mask high bits dropped");
        wr(10'd4, 32'hFFFF_FFFF);
        rd(10'd4, 1, "R6 mask bit0");

        // R5: load equal to alarm does not set
        wr(10'd1, 32'd51);
        wr(10'd7, 32'd0);
        wr(10'd2, 32'd51);
        rd(10'd5, 0, "R5 load onto alarm no set");

        // R7: set and clear on the same edge, set wins
        wr(10'd2, 32'd50);
        idle(HZ - 1);
        wr(10'd7, 32'h1234);
        rd(10'd5, 1, "R7 set wins over clear");
        check("R8 irq with mask", {31'd0, irq}, 32'd1);
        wr(10'd7, 32'h0);
        rd(10'd5, 0, "R7 clear");

        // R5/R8: normal alarm, then masking
        wr(10'd1, 32'd60);
        wr(10'd2, 32'd58);
        idle(2 * HZ + 2);
        rd(10'd5, 1, "R5 alarm hit");
        rd(10'd6, 1, "R8 masked set");
        wr(10'd4, 32'd0);
        rd(10'd6, 0, "R8 masked off");
        rd(10'd5, 1, "R8 raw unaffected by mask");
        check("R8 irq off", {31'd0, irq}, 32'd0);

        // R9: control
        wr(10'd3, 32'd0);
        rd(10'd3, 1, "R9 control reads one");

        // R10: ID bytes and ignored writes
        wr(10'h3F8, 32'h0);
        rd(10'h3F8, 32'h31, "R10 id0 after write");
        rd(10'h3F9, 32'h10, "R10 id1");
        rd(10'h3FA, 32'h14, "R10 id2");
        rd(10'h3FB, 32'h00, "R10 id3");
        rd(10'h3FC, 32'h0D, "R10 id4");
        rd(10'h3FD, 32'hF0, "R10 id5");
        rd(10'h3FE, 32'h05, "R10 id6");
        rd(10'h3FF, 32'hB1, "R10 id7");

        // R11: reserved and clear reads, reserved writes
        wr(10'd8, 32'hFFFF_FFFF);
        wr(10'h200, 32'hFFFF_FFFF);
        rd(10'd8, 0, "R11 reserved low");
        rd(10'h200, 0, "R11 reserved mid");
        rd(10'h3F7, 0, "R11 reserved top");
        rd(10'd7, 0, "R11 clear reads zero");
        rd(10'd1, 32'd60, "R11 alarm untouched");

        // R12: wrap
        wr(10'd2, 32'hFFFF_FFFF);
        idle(HZ);
        rd(10'd0, 32'd0, "R12 wrap to zero");

        idle(2);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule